// File: doc/BRIEF.md
# XOR Chain Connectivity Tester

This block exercises an XOR-chain test structure and judges whether its pins are connected. The chain starts from a constant logic 1 and folds in each of `N` pin values in turn, so its output is the inverted parity of the pins. On a start pulse the tester drives a walking thermometer pattern onto the pins. The pattern runs through `N+1` vectors, from all zeros up to all ones, and each vector fills in one more pin from pin 1. The tester holds each vector for `SETTLE` clock cycles. It samples the chain output at the end of that window and compares it with the value predicted from the number of pins at 1.

A good chain makes the output alternate 1, 0, 1, 0 across the sequence. A pin that is stuck or floating high breaks the sequence from the very first vector. A pin that is stuck or floating low breaks it only once the pattern reaches that pin. The tester therefore reports how many vectors mismatched and the index of the first mismatching vector. Together these two values locate the defective pin.

The chain model includes per-pin fault inputs. With them a board-level open or short can be imposed on any pin, between the driven value and the chain.

Top module: `xchain_tester`

## Requirements
- R1: While reset is asserted, and after it is released, `pins_o` is 0, `done_o` is 0, `pass_o` is 0, and `fail_count_o` and `first_fail_o` are 0.
- R2: `chain_o` equals 1 XOR every effective pin. The effective pin i+1 is `(pins_o[i] | stuck_hi_i[i]) & ~stuck_lo_i[i]`, so stuck-low wins when both fault inputs are set. With all pins at 0 and no faults, `chain_o` is 1.
- R3: A run applies vectors k = 1..N+1 in order, each for exactly `SETTLE` cycles. Vector k drives `pins_o[i]` (pin i+1) to 1 for i < k-1 and to 0 otherwise. Outside a run `pins_o` is 0.
- R4: The expected sample for vector k is 1 when k-1 (the count of ones) is even and 0 when it is odd. A fault-free run ends with `pass_o`=1, `fail_count_o`=0 and `first_fail_o`=0.
- R5: A single pin p stuck high gives `fail_count_o`=p, `first_fail_o`=1 and `pass_o`=0.
- R6: A single pin p stuck low gives `first_fail_o`=p+1, `fail_count_o`=N+1-p and `pass_o`=0.
- R7: `fail_count_o` counts the vectors whose sample differs from the expectation. `first_fail_o` holds the 1-based index of the earliest such vector. Both apply to any fault pattern.
- R8: `done_o` rises (N+1)*SETTLE cycles after the clock edge that accepts the start. It stays high, with the results stable, until the next start.
- R9: A start pulse during a run is ignored and leaves the run's timing and results unchanged.
- R10: A start accepted while idle or done clears `fail_count_o`, `first_fail_o` and `done_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when not running |
| stuck_hi_i | input | N | Per-pin fault: forces the pin high at the chain |
| stuck_lo_i | input | N | Per-pin fault: forces the pin low at the chain (wins over stuck high) |
| pins_o | output | N | Driven test vector, bit i is pin i+1 |
| chain_o | output | 1 | Chain output of the behavioural model |
| done_o | output | 1 | Run complete, results valid |
| pass_o | output | 1 | Run complete with no mismatch |
| fail_count_o | output | $clog2(N+2) | Number of mismatching vectors |
| first_fail_o | output | $clog2(N+2) | Index of the first mismatching vector, 0 if none |

## Verification
The start is accepted at a rising edge E0. Vector k appears on `pins_o` just after edge E0+(k-1)*SETTLE. `chain_o` follows combinationally in the same cycle. The results and `done_o` update at edge E0+(N+1)*SETTLE. The bench drives at falling edges and checks the pins and the chain output at the falling edge that opens each vector window. It checks that `done_o` is still low at the falling edge just before the final sampling edge, and reads the results at the falling edge after it. The cleared results are checked at the falling edge right after E0.

// File: rtl/xchain_pkg.sv
package xchain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } xc_state_e;
endpackage

// File: rtl/xchain_model.sv
module xchain_model #(
  parameter int N = 6
) (
  input  logic [N-1:0] drive_i,
  input  logic [N-1:0] stuck_hi_i,
  input  logic [N-1:0] stuck_lo_i,
  output logic         chain_o
);
  logic [N-1:0] eff;
  logic [N:0]   stage;

  assign eff      = (drive_i | stuck_hi_i) & ~stuck_lo_i;
  assign stage[0] = 1'b1;  // supply-rail seed

  for (genvar g = 0; g < N; g++) begin : g_stage
    assign stage[g+1] = stage[g] ^ eff[g];
  end

  assign chain_o = stage[N];
endmodule

// File: rtl/xchain_seq.sv
module xchain_seq
  import xchain_pkg::*;
#(
  parameter int N      = 6,
  parameter int SETTLE = 3,
  localparam int IW    = $clog2(N + 2),
  localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [N-1:0]  drive_o,
  output logic [IW-1:0] vec_idx_o,
  output logic          sample_o,
  output logic          clear_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N + 1);
  localparam logic [SW-1:0] CNT_END  = SW'(SETTLE - 1);

  xc_state_e     st_q;
  logic [IW-1:0] idx_q;
  logic [SW-1:0] cnt_q;

  assign sample_o  = (st_q == ST_RUN) && (cnt_q == CNT_END);
  assign clear_o   = start_i && (st_q != ST_RUN);
  assign done_o    = (st_q == ST_DONE);
  assign vec_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (cnt_q == CNT_END) begin
            cnt_q <= '0;
            if (idx_q == LAST_IDX) st_q  <= ST_DONE;
            else                   idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (start_i) begin
            st_q  <= ST_RUN;
            idx_q <= IW'(1);
            cnt_q <= '0;
          end
        end
      endcase
    end
  end

  // thermometer: vector k sets pins 1..k-1
  always_comb begin
    drive_o = '0;
    if (st_q == ST_RUN) begin
      for (int i = 0; i < N; i++) drive_o[i] = (IW'(i + 1) < idx_q);
    end
  end

  p_walk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |->
      ($countones(drive_o) == $countones($past(drive_o)) ||
       $countones(drive_o) == $countones($past(drive_o)) + 1));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && start_i && !sample_o) |=>
      (st_q == ST_RUN && idx_q == $past(idx_q)));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (idx_q != '0 && idx_q <= LAST_IDX));
endmodule

// File: rtl/xchain_log.sv
module xchain_log #(
  parameter int N   = 6,
  localparam int IW = $clog2(N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic [IW-1:0] vec_idx_i,
  input  logic          chain_i,
  output logic [IW-1:0] fail_count_o,
  output logic [IW-1:0] first_fail_o
);
  logic expect_bit;
  logic mismatch;

  // k-1 ones: even when k is odd, so expect 1 for odd k
  assign expect_bit = vec_idx_i[0];
  assign mismatch   = sample_i && (chain_i != expect_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_count_o <= '0;
      first_fail_o <= '0;
    end else if (clear_i) begin
      fail_count_o <= '0;
      first_fail_o <= '0;
    end else if (mismatch) begin
      fail_count_o <= fail_count_o + 1'b1;
      if (first_fail_o == '0) first_fail_o <= vec_idx_i;
    end
  end

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_count_o <= IW'(N + 1));

  p_first_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_fail_o != '0 && !clear_i) |=> (first_fail_o == $past(first_fail_o)));

  p_first_vs_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_fail_o == '0) == (fail_count_o == '0));
endmodule

// File: rtl/xchain_tester.sv
module xchain_tester #(
  parameter int N      = 6,
  parameter int SETTLE = 3,
  localparam int IW    = $clog2(N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  stuck_hi_i,
  input  logic [N-1:0]  stuck_lo_i,
  output logic [N-1:0]  pins_o,
  output logic          chain_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [IW-1:0] fail_count_o,
  output logic [IW-1:0] first_fail_o
);
  logic [IW-1:0] vec_idx;
  logic          sample;
  logic          clear;

  xchain_seq #(.N(N), .SETTLE(SETTLE)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .drive_o   (pins_o),
    .vec_idx_o (vec_idx),
    .sample_o  (sample),
    .clear_o   (clear),
    .done_o    (done_o)
  );

  xchain_model #(.N(N)) u_model (
    .drive_i    (pins_o),
    .stuck_hi_i (stuck_hi_i),
    .stuck_lo_i (stuck_lo_i),
    .chain_o    (chain_o)
  );

  xchain_log #(.N(N)) u_log (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear),
    .sample_i     (sample),
    .vec_idx_i    (vec_idx),
    .chain_i      (chain_o),
    .fail_count_o (fail_count_o),
    .first_fail_o (first_fail_o)
  );

  assign pass_o = done_o && (fail_count_o == '0);

  p_done_pins_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pins_o == '0));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(fail_count_o) && $stable(first_fail_o)));

  p_seed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_o == '0 && stuck_hi_i == '0) |-> chain_o);
endmodule

// File: tb/xchain_tester_tb_top.sv
module xchain_tester_tb_top;
  localparam int N      = 6;
  localparam int SETTLE = 3;
  localparam int IW     = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  hi = '0;
  logic [N-1:0]  lo = '0;
  logic [N-1:0]  pins;
  logic          chain, done, pass;
  logic [IW-1:0] fcnt, ffirst;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  xchain_tester #(.N(N), .SETTLE(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .stuck_hi_i(hi), .stuck_lo_i(lo),
    .pins_o(pins), .chain_o(chain), .done_o(done), .pass_o(pass),
    .fail_count_o(fcnt), .first_fail_o(ffirst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] thermo(input int ones);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) if (i < ones) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic chain_ref(input logic [N-1:0] d, input logic [N-1:0] h,
                                     input logic [N-1:0] l);
    return 1'b1 ^ (^((d | h) & ~l));
  endfunction

  task automatic expect_result(input logic [N-1:0] h, input logic [N-1:0] l,
                               output int cnt, output int first);
    cnt = 0; first = 0;
    for (int k = 1; k <= N + 1; k++) begin
      logic e;
      e = ((k - 1) % 2 == 0);
      if (chain_ref(thermo(k - 1), h, l) != e) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic run_case(input logic [N-1:0] h, input logic [N-1:0] l,
                          input bit mid_start, input int want_cnt, input int want_first,
                          input string req);
    int ec, ef;
    expect_result(h, l, ec, ef);
    if (want_cnt >= 0) begin
      check(ec == want_cnt, req, "ref count", ec, want_cnt);
      check(ef == want_first, req, "ref first", ef, want_first);
    end
    hi = h; lo = l;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(fcnt == '0 && ffirst == '0, "R10", "cleared results", int'(fcnt), 0);
    check(done == 1'b0, "R10", "done cleared", int'(done), 0);
    for (int k = 1; k <= N + 1; k++) begin
      check(pins == thermo(k - 1), "R3", "vector pins", int'(pins), int'(thermo(k - 1)));
      check(chain == chain_ref(thermo(k - 1), h, l), "R2", "chain out",
            int'(chain), int'(chain_ref(thermo(k - 1), h, l)));
      for (int s = 0; s < SETTLE; s++) begin
        start = (mid_start && k == 2 && s == 0);
        if (k == N + 1 && s == SETTLE - 1)
          check(done == 1'b0, "R8", "done before last sample", int'(done), 0);
        @(posedge clk); @(negedge clk);
      end
      start = 1'b0;
    end
    check(done == 1'b1, "R8", "done at (N+1)*SETTLE", int'(done), 1);
    check(int'(fcnt) == ec, "R7", "fail count", int'(fcnt), ec);
    check(int'(ffirst) == ef, "R7", "first fail", int'(ffirst), ef);
    check(pass == (ec == 0), "R4", "pass flag", int'(pass), int'(ec == 0));
    check(pins == '0, "R3", "pins idle after run", int'(pins), 0);
    if (mid_start)
      check(int'(fcnt) == ec && done, "R9", "mid-run start ignored", int'(fcnt), ec);
    repeat (2) @(negedge clk);
    check(done && int'(ffirst) == ef, "R8", "results held", int'(ffirst), ef);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(pins == '0 && done == 1'b0 && pass == 1'b0, "R1", "in reset", int'(pins), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pins == '0 && done == 1'b0 && pass == 1'b0, "R1", "after reset", int'(done), 0);
    check(fcnt == '0 && ffirst == '0, "R1", "results after reset", int'(fcnt), 0);
    check(chain == 1'b1, "R2", "seeded chain all zeros", int'(chain), 1);

    run_case('0, '0, 1'b0, 0, 0, "R4");
    run_case(N'(1), '0, 1'b0, 1, 1, "R5");
    run_case(N'(1) << (N - 1), '0, 1'b0, N, 1, "R5");
    run_case(N'(1) << 2, '0, 1'b0, 3, 1, "R5");
    run_case('0, N'(1), 1'b0, N, 2, "R6");
    run_case('0, N'(1) << (N - 1), 1'b0, 1, N + 1, "R6");
    run_case('0, N'(1) << 3, 1'b0, N - 3, 5, "R6");
    run_case(N'(1), N'(1), 1'b0, N, 2, "R2");
    run_case('0, N'(1) << 1, 1'b1, N - 1, 3, "R9");
    run_case('0, '0, 1'b1, 0, 0, "R9");

    for (int r = 0; r < 24; r++) begin
      logic [N-1:0] rh, rl;
      rh = '0; rl = '0;
      if (r % 3 == 0) begin
        rh = N'($urandom);
        rl = N'($urandom);
      end else if (r % 3 == 1) begin
        rh[$urandom % N] = 1'b1;
      end else begin
        rl[$urandom % N] = 1'b1;
      end
      run_case(rh, rl, ($urandom % 4) == 0, -1, -1, "R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule